// File: doc/BRIEF.md
# Multi-Cycle Instruction Fetch Sequencer

This block is the control sequencer of a small 16-bit processor. It walks each instruction through a fixed set of timing states: two fetch states and up to two execute states. It waits in a state whenever memory has not yet reported ready. The instruction decoder produces a 17-bit control word for the datapath, and that word passes through this block. In the fetch states and in the memory phase of load and store instructions, the block replaces three fields of the word with its own values. Those fields select the address source of the memory address register, load that register, and advance the program counter.

The block also drives a one-hot timing-state vector. The decoder uses it to shape its control word for each step. A single-bit instruction-register load strobe marks the cycle in which the fetched word is captured. Reset is synchronous and active low. The decoder, the datapath and the memory are outside this block.

Top module: `fetch_sequencer`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, the next state is the first fetch state. While `rst_n` is 0, the address-select field, the address-load field, the PC-increment field and `ir_load_o` are all 0.
- R2: In the first fetch state, the address-select field (`cw_o[12]`) and the address-load field (`cw_o[13]`) are 1 and the PC-increment field (`cw_o[14]`) is 0. The next state is always the second fetch state.
- R3: In the second fetch state with `mem_rdy_i` at 0, the state holds. The address-select, address-load and PC-increment fields are 0.
- R4: In the second fetch state with `mem_rdy_i` at 1, the PC-increment field and `ir_load_o` are 1 in that same cycle, and the next state is the first execute state.
- R5: In the first execute state, if `mem_op_i` is 0 (ALU-type) or `mem_rdy_i` is 1, the next state is the first fetch state.
- R6: In the first execute state, if `mem_op_i` is 1 (load/store) and `mem_rdy_i` is 0, the next state is the second execute state.
- R7: In the second execute state, the address-select field is 1 and the address-load and PC-increment fields are 0. The state holds while `mem_rdy_i` is 0 and goes to the first fetch state when it is 1.
- R8: In the first execute state, the address-select and address-load fields pass through from `cw_i` unchanged. The PC-increment field is 0 in every state except R4's cycle, and `ir_load_o` is 1 only in R4's cycle.
- R9: Every bit of `cw_o` other than bits 12, 13 and 14 equals the same bit of `cw_i` in every state, including during reset.
- R10: `tstate_o` is one-hot: bit 0 is the first fetch state, bit 1 the second fetch state, bit 2 the first execute state and bit 3 the second execute state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdy_i | input | 1 | Memory has completed the current access |
| mem_op_i | input | 1 | Current instruction is a load or store (1) or ALU-type (0) |
| cw_i | input | 17 | Control word from the instruction decoder |
| cw_o | output | 17 | Control word to the datapath, with the override fields applied |
| tstate_o | output | 4 | One-hot timing state |
| ir_load_o | output | 1 | Capture the fetched word into the instruction register |

## Verification
The bench builds the block with its default parameters. These give a 17-bit word with the address-select, address-load and PC-increment fields at bits 12, 13 and 14. With these values, random control words exercise all fourteen pass-through bits next to the three override bits. Directed runs delay ready by zero to three cycles, in both fetch and execute, for ALU-type and load/store instructions. A random phase adds resets at arbitrary states.

// File: rtl/seq_pkg.sv
// Package seq_pkg
// Shared state encoding and sizes for the fetch sequencer.
// Assumes exactly four timing states; the one-hot bit order follows the enum order.
package seq_pkg;

    localparam int unsigned NSTATE = 4;
    localparam int unsigned ST_W   = $clog2(NSTATE);

    typedef enum logic [ST_W-1:0] {
        ST_FETCH_A = 2'd0,
        ST_FETCH_B = 2'd1,
        ST_EXEC_A  = 2'd2,
        ST_EXEC_B  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/seq_state.sv
// Module seq_state
// State register and next-state logic of the sequencer.
// Assumes mem_rdy_i is stable ahead of the clock edge and reset is synchronous, active low.
module seq_state
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mem_rdy_i,
    input  logic       mem_op_i,
    output seq_state_e state_q
);

    seq_state_e state_d;

    // Pick the following state from the current state, ready and instruction type.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH_A: state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = mem_rdy_i ? ST_EXEC_A : ST_FETCH_B;
            ST_EXEC_A:  state_d = (!mem_op_i || mem_rdy_i) ? ST_FETCH_A : ST_EXEC_B;
            ST_EXEC_B:  state_d = mem_rdy_i ? ST_FETCH_A : ST_EXEC_B;
            default:    state_d = ST_FETCH_A;
        endcase
    end

    // Register the state; reset forces the first fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_A;
        end else begin
            state_q <= state_d;
        end
    end

    p_reset_fetch_r1: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_FETCH_A);

    p_fetch_a_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH_A |=> state_q == ST_FETCH_B);

    p_fetch_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_B && !mem_rdy_i) |=> state_q == ST_FETCH_B);

    p_fetch_b_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_B && mem_rdy_i) |=> state_q == ST_EXEC_A);

    p_exec_a_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC_A && (!mem_op_i || mem_rdy_i)) |=> state_q == ST_FETCH_A);

    p_exec_a_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC_A && mem_op_i && !mem_rdy_i) |=> state_q == ST_EXEC_B);

    p_exec_b_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC_B && mem_rdy_i) |=> state_q == ST_FETCH_A);

endmodule

// File: rtl/seq_ctrl.sv
// Module seq_ctrl
// Decodes the state into the override controls and the one-hot timing vector.
// Assumes that a field whose force flag is 0 is taken from the decoder word downstream.
module seq_ctrl
    import seq_pkg::*;
(
    input  logic              rst_n,
    input  logic              mem_rdy_i,
    input  seq_state_e        state_q,
    output logic              sel_frc,
    output logic              sel_val,
    output logic              ld_frc,
    output logic              ld_val,
    output logic              pci_val,
    output logic              ir_load,
    output logic [NSTATE-1:0] tvec
);

    // Produce the force flags and the forced values for each state.
    always_comb begin
        sel_frc = 1'b1;
        sel_val = 1'b0;
        ld_frc  = 1'b1;
        ld_val  = 1'b0;
        pci_val = 1'b0;
        ir_load = 1'b0;
        if (rst_n) begin
            case (state_q)
                ST_FETCH_A: begin
                    sel_val = 1'b1;
                    ld_val  = 1'b1;
                end
                ST_FETCH_B: begin
                    pci_val = mem_rdy_i;
                    ir_load = mem_rdy_i;
                end
                ST_EXEC_A: begin
                    sel_frc = 1'b0;
                    ld_frc  = 1'b0;
                end
                ST_EXEC_B: begin
                    sel_val = 1'b1;
                end
                default: begin
                    sel_val = 1'b0;
                end
            endcase
        end
    end

    // One bit of the timing vector for each state, in enum order.
    for (genvar g = 0; g < NSTATE; g++) begin : g_tvec
        assign tvec[g] = (state_q == seq_state_e'(g));
    end

endmodule

// File: rtl/seq_overlay.sv
// Module seq_overlay
// Replaces the three sequencer-owned fields of the decoder word and passes all other bits.
// Assumes the three field positions are distinct and lie inside the word.
module seq_overlay #(
    parameter int unsigned CW_W     = 17,
    parameter int unsigned MSEL_POS = 12,
    parameter int unsigned MLD_POS  = 13,
    parameter int unsigned PCI_POS  = 14
) (
    input  logic [CW_W-1:0] cw_in,
    input  logic            sel_frc,
    input  logic            sel_val,
    input  logic            ld_frc,
    input  logic            ld_val,
    input  logic            pci_val,
    output logic [CW_W-1:0] cw_out
);

    // Choose, per bit, between the decoder value and the sequencer value.
    for (genvar g = 0; g < CW_W; g++) begin : g_bit
        if (g == MSEL_POS) begin : g_sel
            assign cw_out[g] = sel_frc ? sel_val : cw_in[g];
        end else if (g == MLD_POS) begin : g_ld
            assign cw_out[g] = ld_frc ? ld_val : cw_in[g];
        end else if (g == PCI_POS) begin : g_pci
            assign cw_out[g] = pci_val;
        end else begin : g_pass
            assign cw_out[g] = cw_in[g];
        end
    end

endmodule

// File: rtl/fetch_sequencer.sv
// Module fetch_sequencer
// Top of the multi-cycle fetch/execute sequencer: state register, control decode, word overlay.
// Assumes the decoder word and the instruction type are valid in every cycle.
module fetch_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned CW_W     = 17,
    parameter int unsigned MSEL_POS = 12,
    parameter int unsigned MLD_POS  = 13,
    parameter int unsigned PCI_POS  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rdy_i,
    input  logic              mem_op_i,
    input  logic [CW_W-1:0]   cw_i,
    output logic [CW_W-1:0]   cw_o,
    output logic [NSTATE-1:0] tstate_o,
    output logic              ir_load_o
);

    seq_state_e state_q;
    logic       sel_frc;
    logic       sel_val;
    logic       ld_frc;
    logic       ld_val;
    logic       pci_val;

    seq_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdy_i (mem_rdy_i),
        .mem_op_i  (mem_op_i),
        .state_q   (state_q)
    );

    seq_ctrl u_ctrl (
        .rst_n     (rst_n),
        .mem_rdy_i (mem_rdy_i),
        .state_q   (state_q),
        .sel_frc   (sel_frc),
        .sel_val   (sel_val),
        .ld_frc    (ld_frc),
        .ld_val    (ld_val),
        .pci_val   (pci_val),
        .ir_load   (ir_load_o),
        .tvec      (tstate_o)
    );

    seq_overlay #(
        .CW_W     (CW_W),
        .MSEL_POS (MSEL_POS),
        .MLD_POS  (MLD_POS),
        .PCI_POS  (PCI_POS)
    ) u_overlay (
        .cw_in   (cw_i),
        .sel_frc (sel_frc),
        .sel_val (sel_val),
        .ld_frc  (ld_frc),
        .ld_val  (ld_val),
        .pci_val (pci_val),
        .cw_out  (cw_o)
    );

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tstate_o) == 1);

    p_pcinc_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cw_o[PCI_POS] |-> (tstate_o[1] && mem_rdy_i));

    p_irload_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load_o |-> (tstate_o[1] && mem_rdy_i));

    p_exec_b_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tstate_o[3] |-> (cw_o[MSEL_POS] && !cw_o[MLD_POS]));

    p_fetch_a_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tstate_o[0] |-> (cw_o[MSEL_POS] && cw_o[MLD_POS]));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!cw_o[MSEL_POS] && !cw_o[MLD_POS] && !cw_o[PCI_POS] && !ir_load_o));

endmodule

// File: tb/test_fetch_sequencer.sv
module test_fetch_sequencer;

    localparam int SEL = 12;
    localparam int LD  = 13;
    localparam int PCI = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rdy_i = 1'b0;
    logic        mem_op_i = 1'b0;
    logic [16:0] cw_i = '0;
    logic [16:0] cw_o;
    logic [3:0]  tstate_o;
    logic        ir_load_o;

    int    checks = 0;
    int    errors = 0;
    int    ms = 0;
    bit    mvalid = 0;
    string why = "R1";
    bit    done = 0;

    always #10 clk = ~clk;

    fetch_sequencer i_fetch_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdy_i (mem_rdy_i),
        .mem_op_i  (mem_op_i),
        .cw_i      (cw_i),
        .cw_o      (cw_o),
        .tstate_o  (tstate_o),
        .ir_load_o (ir_load_o)
    );

    task automatic chk(input string tag, input string what, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (state %0d)", tag, what, act, exp, ms);
        end
    endtask

    function automatic logic [2:0] exp_ovr(input int st, input logic [16:0] cw, input logic rdy, input logic rn);
        // bits: {pci, ld, sel}
        if (!rn) return 3'b000;
        case (st)
            0: return 3'b011;
            1: return {rdy, 2'b00};
            2: return {1'b0, cw[LD], cw[SEL]};
            default: return 3'b001;
        endcase
    endfunction

    function automatic string sel_tag(input int st, input logic rn);
        if (!rn) return "R1";
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic step(input logic [16:0] cw, input logic rdy, input logic mem, input logic rn);
        logic [2:0]  eo;
        logic [16:0] mask;
        @(negedge clk);
        cw_i = cw; mem_rdy_i = rdy; mem_op_i = mem; rst_n = rn;
        #2;
        mask = ~(17'd7 << SEL);
        eo = exp_ovr(ms, cw, rdy, rn);
        chk("R9", "pass bits", cw_o & mask, cw & mask);
        chk(sel_tag(ms, rn), "addr select", {16'd0, cw_o[SEL]}, {16'd0, eo[0]});
        chk(sel_tag(ms, rn), "addr load", {16'd0, cw_o[LD]}, {16'd0, eo[1]});
        chk((ms == 1 && rn) ? "R4" : "R8", "pc inc", {16'd0, cw_o[PCI]}, {16'd0, eo[2]});
        chk((ms == 1 && rn) ? "R4" : "R8", "ir load", {16'd0, ir_load_o},
            {16'd0, (rn && ms == 1 && rdy)});
        if (mvalid) begin
            chk(why, "state", {13'd0, tstate_o}, 17'd1 << ms);
            chk("R10", "onehot", {16'd0, ($countones(tstate_o) == 1)}, 17'd1);
        end
        @(posedge clk);
        if (!rn) begin
            ms = 0; why = "R1"; mvalid = 1;
        end else begin
            case (ms)
                0: begin ms = 1; why = "R2"; end
                1: if (rdy) begin ms = 2; why = "R4"; end else begin why = "R3"; end
                2: if (!mem || rdy) begin ms = 0; why = "R5"; end else begin ms = 3; why = "R6"; end
                default: if (rdy) begin ms = 0; why = "R7"; end else begin why = "R7"; end
            endcase
        end
    endtask

    // One instruction: fetch ready after df cycles, execute ready after de cycles.
    task automatic instr(input logic mem, input int df, input int de);
        step(17'($urandom), 1'b0, mem, 1'b1);
        for (int k = 0; k < df; k++) step(17'($urandom), 1'b0, mem, 1'b1);
        step(17'($urandom), 1'b1, mem, 1'b1);
        if (mem && de > 0) begin
            for (int k = 0; k < de; k++) step(17'($urandom), 1'b0, mem, 1'b1);
            step(17'($urandom), 1'b1, mem, 1'b1);
        end else begin
            step(17'($urandom), mem, mem, 1'b1);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(17'h1FFFF, 1'b1, 1'b1, 1'b0);
        step(17'h0AAAA, 1'b1, 1'b0, 1'b0);
        for (int m = 0; m < 2; m++)
            for (int df = 0; df < 4; df++)
                for (int de = 0; de < 4; de++)
                    instr(m[0], df, de);
        // reset in the middle of a load/store wait
        step(17'h00000, 1'b0, 1'b1, 1'b1);
        step(17'h00000, 1'b1, 1'b1, 1'b1);
        step(17'h1FFFF, 1'b0, 1'b1, 1'b1);
        step(17'h1FFFF, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3000; i++)
            step(17'($urandom), ($urandom % 3) != 0, 1'($urandom),
                 ($urandom % 64) != 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule